// File: doc/BRIEF.md
# Two-Processor Priority Interrupt Controller

This block gathers a large set of interrupt request lines and, for each of two processors (a main processor and an I/O processor), presents the single most urgent pending source as a request flag plus a vector number. The vector number is the source's index. Every source carries a small priority field and a steering bit. The steering bit decides which processor's arbiter sees the source. Both arbiters use the same priority scale. A per-processor current-priority register suppresses every request whose level does not exceed it. This lets software run at a raised level, for example to implement a priority ceiling around a shared resource.

When a processor acknowledges its presented request, the controller saves the running level on a per-processor stack and raises the running level to the level of the source being serviced. An end-of-interrupt write restores the saved level. A small group of the lowest source positions have no hardware line; software sets and clears them through register writes. A band of the highest positions is reserved and can never request. A separate external urgent input bypasses arbitration and masking and drives the main processor's critical-interrupt output after one register stage.

Configuration uses a plain write port and a combinational read port. When the top address bit is 1, the remaining bits select a source: data bits [PRIO_W-1:0] hold its priority and bit PRIO_W holds its steering. When the top address bit is 0, the address selects a control word: 0 is the main processor's current priority, 1 is the I/O processor's current priority, 2 is end-of-interrupt for the main processor, 3 is end-of-interrupt for the I/O processor, 4 sets software requests (reads back as the software pending bits), and 5 clears software requests.

Top module: `prio_intc`

## Requirements
- R1: For each processor, the vector output equals the index of the pending, enabled source steered to it that has the highest priority.
- R2: Among eligible sources with equal priority, the lowest index is presented.
- R3: A source whose priority field is 0 never requests, and any presented request has a nonzero level.
- R4: The top NUM_RSVD source positions never request. Writes to their configuration are ignored, and their configuration reads back as 0.
- R5: Sources 0 to NUM_SW-1 ignore their hardware lines. A write of data bit n to control address 4 makes source n pending, a write of data bit n to address 5 clears it, and address 4 reads back the software pending bits.
- R6: A processor's request flag is asserted only when the best eligible level is strictly greater than that processor's current priority.
- R7: A steering bit of 0 routes a source to the main processor, and a steering bit of 1 routes it to the I/O processor.
- R8: The request and vector outputs are registered. A hardware line that rises before clock edge k is reflected on the outputs after edge k+1, and a current-priority write takes effect on the outputs one cycle after it is applied.
- R9: An acknowledge while the request flag is high pushes the current priority onto that processor's stack and sets the current priority to the presented level. The request flag is low in the following cycle.
- R10: An end-of-interrupt write pops the most recently saved level into the current priority, and on an empty stack it has no effect. An acknowledge while the stack holds STACK_DEPTH entries is ignored.
- R11: The critical output follows the external urgent input one cycle later, regardless of masking or steering.
- R12: After reset, both request flags, the critical output, all priorities, steering bits, current priorities and software pending bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Level-sensitive hardware request lines |
| nmi_i | input | 1 | External urgent request for the main processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | IDX_W+1 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | IDX_W+1 | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| ack_cpu_i | input | 1 | Main processor acknowledge |
| ack_iop_i | input | 1 | I/O processor acknowledge |
| req_cpu_o | output | 1 | Main processor request flag |
| vec_cpu_o | output | IDX_W | Main processor vector |
| req_iop_o | output | 1 | I/O processor request flag |
| vec_iop_o | output | IDX_W | I/O processor vector |
| crit_o | output | 1 | Main processor critical interrupt |

## Verification
The bench builds the block with 40 sources, 4 reserved positions at indices 36 to 39, 8 software sources and a stack depth of 4. Forty sources keep each randomized reconfiguration of every priority and steering bit short, so dozens of random rounds can be compared against the bench's own arbitration model. A stack of depth 4 makes it possible to fill the stack, observe the ignored acknowledge at full depth, and unwind past the bottom within a few hundred cycles. That corner would need sixteen nested services at the default depth.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // Control word selectors in the lower address half
   typedef enum logic [2:0] {
      CTL_CUR_MAIN = 3'd0,
      CTL_CUR_IOP  = 3'd1,
      CTL_EOI_MAIN = 3'd2,
      CTL_EOI_IOP  = 3'd3,
      CTL_SW_SET   = 3'd4,
      CTL_SW_CLR   = 3'd5
   } ctl_sel_e;

   localparam int NUM_CTX = 2;   // main processor = 0, I/O processor = 1

endpackage

// File: rtl/intc_stack.sv
module intc_stack #(
   parameter int W     = 4,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] top_o,
   output logic         empty_o,
   output logic         full_o
);
   localparam int PTR_W = $clog2(DEPTH + 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sp_q <= '0;
      else if (push_i) sp_q <= sp_q + PTR_W'(1);
      else if (pop_i)  sp_q <= sp_q - PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < DEPTH; e++) begin
         if (push_i && sp_q == PTR_W'(e)) mem[e] <= data_i;
      end
   end

   always_comb begin
      top_o = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (sp_q == PTR_W'(e + 1)) top_o = mem[e];
      end
   end

   assign empty_o = (sp_q == '0);
   assign full_o  = (sp_q == PTR_W'(DEPTH));

endmodule

// File: rtl/intc_srcbank.sv
module intc_srcbank #(
   parameter int NUM_SRC  = 316,
   parameter int NUM_RSVD = 22,
   parameter int NUM_SW   = 8,
   parameter int PRIO_W   = 4,
   parameter int IDX_W    = 9
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_SRC-1:0]               irq_i,
   input  logic                             cfg_we,
   input  logic [IDX_W-1:0]                 cfg_idx,
   input  logic [PRIO_W-1:0]                cfg_prio,
   input  logic                             cfg_steer,
   input  logic [NUM_SW-1:0]                sw_set_i,
   input  logic [NUM_SW-1:0]                sw_clr_i,
   output logic [NUM_SRC-1:0]               pend_o,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o,
   output logic [NUM_SRC-1:0]               steer_o,
   output logic [NUM_SW-1:0]                sw_pend_o
);
   localparam int FIRST_RSVD = NUM_SRC - NUM_RSVD;

   logic [NUM_SW-1:0] sw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sw_q <= '0;
      else        sw_q <= (sw_q & ~sw_clr_i) | sw_set_i;
   end
   assign sw_pend_o = sw_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i >= FIRST_RSVD) begin : g_rsvd
         logic unused_line;
         assign unused_line = irq_i[i];
         assign pend_o[i]   = 1'b0;
         assign prio_o[i]   = '0;
         assign steer_o[i]  = 1'b0;
      end else begin : g_live
         logic [PRIO_W-1:0] prio_q;
         logic              steer_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prio_q  <= '0;
               steer_q <= 1'b0;
            end else if (cfg_we && cfg_idx == IDX_W'(i)) begin
               prio_q  <= cfg_prio;
               steer_q <= cfg_steer;
            end
         end
         assign prio_o[i]  = prio_q;
         assign steer_o[i] = steer_q;

         if (i < NUM_SW) begin : g_soft
            logic unused_line;
            assign unused_line = irq_i[i];
            assign pend_o[i]   = sw_q[i];
         end else begin : g_hard
            logic line_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) line_q <= 1'b0;
               else        line_q <= irq_i[i];
            end
            assign pend_o[i] = line_q;
         end
      end
   end

endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
   parameter int NUM_SRC   = 316,
   parameter int PRIO_W    = 4,
   parameter int IDX_W     = 9,
   parameter bit STEER_SEL = 1'b0
) (
   input  logic [NUM_SRC-1:0]             pend_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   input  logic [NUM_SRC-1:0]             steer_i,
   output logic                           valid_o,
   output logic [PRIO_W-1:0]              prio_o,
   output logic [IDX_W-1:0]               idx_o
);
   // Ascending scan with strict compare: the lowest index keeps a tie.
   always_comb begin
      prio_o = '0;
      idx_o  = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pend_i[i] && steer_i[i] == STEER_SEL && prio_i[i] > prio_o) begin
            prio_o = prio_i[i];
            idx_o  = IDX_W'(i);
         end
      end
   end
   assign valid_o = (prio_o != '0);

endmodule

// File: rtl/intc_ctx.sv
module intc_ctx #(
   parameter int PRIO_W = 4,
   parameter int IDX_W  = 9,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              best_valid_i,
   input  logic [PRIO_W-1:0] best_prio_i,
   input  logic [IDX_W-1:0]  best_idx_i,
   input  logic              ack_i,
   input  logic              eoi_i,
   input  logic              cur_we_i,
   input  logic [PRIO_W-1:0] cur_wdata_i,
   output logic              req_o,
   output logic [IDX_W-1:0]  vec_o,
   output logic [PRIO_W-1:0] lvl_o,
   output logic [PRIO_W-1:0] cur_o,
   output logic              full_o
);
   logic              req_q;
   logic [IDX_W-1:0]  vec_q;
   logic [PRIO_W-1:0] lvl_q, cur_q, top;
   logic              full, empty, take, drop;

   assign take = ack_i && req_q && !full;
   assign drop = !take && eoi_i && !empty;

   intc_stack #(.W(PRIO_W), .DEPTH(DEPTH)) u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (take),
      .pop_i   (drop),
      .data_i  (cur_q),
      .top_o   (top),
      .empty_o (empty),
      .full_o  (full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         req_q <= 1'b0;
         vec_q <= '0;
         lvl_q <= '0;
      end else begin
         if (take)          cur_q <= lvl_q;
         else if (drop)     cur_q <= top;
         else if (cur_we_i) cur_q <= cur_wdata_i;
         req_q <= !take && best_valid_i && (best_prio_i > cur_q);
         vec_q <= best_idx_i;
         lvl_q <= best_prio_i;
      end
   end

   assign req_o  = req_q;
   assign vec_o  = vec_q;
   assign lvl_o  = lvl_q;
   assign cur_o  = cur_q;
   assign full_o = full;

endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import intc_pkg::*;
#(
   parameter int NUM_SRC     = 316,
   parameter int NUM_RSVD    = 22,
   parameter int NUM_SW      = 8,
   parameter int PRIO_W      = 4,
   parameter int STACK_DEPTH = 16,
   parameter int DATA_W      = 8,
   localparam int IDX_W      = $clog2(NUM_SRC),
   localparam int ADDR_W     = IDX_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_i,
   input  logic                nmi_i,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                ack_cpu_i,
   input  logic                ack_iop_i,
   output logic                req_cpu_o,
   output logic [IDX_W-1:0]    vec_cpu_o,
   output logic                req_iop_o,
   output logic [IDX_W-1:0]    vec_iop_o,
   output logic                crit_o
);
   // Elaboration-time parameter checks
   if (IDX_W < 4) begin : g_bad_count
      $error("prio_intc: NUM_SRC must exceed 8");
   end
   if (NUM_SW + NUM_RSVD >= NUM_SRC) begin : g_bad_split
      $error("prio_intc: software plus reserved sources leave no hardware source");
   end
   if (NUM_SW < 1 || NUM_SW > DATA_W) begin : g_bad_sw
      $error("prio_intc: NUM_SW must be 1..DATA_W");
   end
   if (DATA_W < PRIO_W + 1) begin : g_bad_data
      $error("prio_intc: DATA_W too narrow for priority plus steering");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("prio_intc: STACK_DEPTH must be positive");
   end

   logic [NUM_SRC-1:0]               pend_w, steer_w;
   logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_w;
   logic [NUM_SW-1:0]                sw_pend_w, sw_set_w, sw_clr_w;
   logic [NUM_CTX-1:0]               req_w, ack_w, eoi_w, curwe_w, full_w;
   logic [NUM_CTX-1:0][IDX_W-1:0]    vec_w;
   logic [NUM_CTX-1:0][PRIO_W-1:0]   lvl_w, cur_w;
   logic                             cfg_we, ctl_wr, ctl_rd, crit_q;
   ctl_sel_e                         wsel, rsel;
   logic [IDX_W-1:0]                 rd_idx;
   logic                             unused_wdata;

   assign unused_wdata = ^wr_data;

   // Write decode
   assign cfg_we = wr_en && wr_addr[ADDR_W-1];
   assign ctl_wr = wr_en && !wr_addr[ADDR_W-1] && ((wr_addr[IDX_W-1:0] >> 3) == '0);
   assign wsel   = ctl_sel_e'(wr_addr[2:0]);

   assign curwe_w[0] = ctl_wr && wsel == CTL_CUR_MAIN;
   assign curwe_w[1] = ctl_wr && wsel == CTL_CUR_IOP;
   assign eoi_w[0]   = ctl_wr && wsel == CTL_EOI_MAIN;
   assign eoi_w[1]   = ctl_wr && wsel == CTL_EOI_IOP;
   assign sw_set_w   = (ctl_wr && wsel == CTL_SW_SET) ? wr_data[NUM_SW-1:0] : '0;
   assign sw_clr_w   = (ctl_wr && wsel == CTL_SW_CLR) ? wr_data[NUM_SW-1:0] : '0;
   assign ack_w      = {ack_iop_i, ack_cpu_i};

   intc_srcbank #(
      .NUM_SRC(NUM_SRC), .NUM_RSVD(NUM_RSVD), .NUM_SW(NUM_SW),
      .PRIO_W(PRIO_W), .IDX_W(IDX_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_i     (irq_i),
      .cfg_we    (cfg_we),
      .cfg_idx   (wr_addr[IDX_W-1:0]),
      .cfg_prio  (wr_data[PRIO_W-1:0]),
      .cfg_steer (wr_data[PRIO_W]),
      .sw_set_i  (sw_set_w),
      .sw_clr_i  (sw_clr_w),
      .pend_o    (pend_w),
      .prio_o    (prio_w),
      .steer_o   (steer_w),
      .sw_pend_o (sw_pend_w)
   );

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      logic              bvalid;
      logic [PRIO_W-1:0] bprio;
      logic [IDX_W-1:0]  bidx;

      intc_arb #(
         .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W),
         .STEER_SEL(c == 1)
      ) u_arb (
         .pend_i  (pend_w),
         .prio_i  (prio_w),
         .steer_i (steer_w),
         .valid_o (bvalid),
         .prio_o  (bprio),
         .idx_o   (bidx)
      );

      intc_ctx #(.PRIO_W(PRIO_W), .IDX_W(IDX_W), .DEPTH(STACK_DEPTH)) u_ctx (
         .clk          (clk),
         .rst_n        (rst_n),
         .best_valid_i (bvalid),
         .best_prio_i  (bprio),
         .best_idx_i   (bidx),
         .ack_i        (ack_w[c]),
         .eoi_i        (eoi_w[c]),
         .cur_we_i     (curwe_w[c]),
         .cur_wdata_i  (wr_data[PRIO_W-1:0]),
         .req_o        (req_w[c]),
         .vec_o        (vec_w[c]),
         .lvl_o        (lvl_w[c]),
         .cur_o        (cur_w[c]),
         .full_o       (full_w[c])
      );
   end

   // Urgent input: one register stage, no arbitration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) crit_q <= 1'b0;
      else        crit_q <= nmi_i;
   end

   // Read mux
   assign rd_idx = rd_addr[IDX_W-1:0];
   assign ctl_rd = !rd_addr[ADDR_W-1] && ((rd_idx >> 3) == '0);
   assign rsel   = ctl_sel_e'(rd_addr[2:0]);

   always_comb begin
      rd_data = '0;
      if (rd_addr[ADDR_W-1]) begin
         if (int'(rd_idx) < NUM_SRC) rd_data = DATA_W'({steer_w[rd_idx], prio_w[rd_idx]});
      end else if (ctl_rd) begin
         case (rsel)
            CTL_CUR_MAIN: rd_data = DATA_W'(cur_w[0]);
            CTL_CUR_IOP:  rd_data = DATA_W'(cur_w[1]);
            CTL_SW_SET:   rd_data = DATA_W'(sw_pend_w);
            default:      rd_data = '0;
         endcase
      end
   end

   assign req_cpu_o = req_w[0];
   assign vec_cpu_o = vec_w[0];
   assign req_iop_o = req_w[1];
   assign vec_iop_o = vec_w[1];
   assign crit_o    = crit_q;

endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int NUM_SRC  = 316,
   parameter int NUM_RSVD = 22,
   parameter int PRIO_W   = 4,
   parameter int IDX_W    = 9
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   nmi_i,
   input logic                   crit_o,
   input logic [1:0]             req,
   input logic [1:0]             ack,
   input logic [1:0]             full,
   input logic [1:0][IDX_W-1:0]  vec,
   input logic [1:0][PRIO_W-1:0] lvl,
   input logic [1:0][PRIO_W-1:0] cur
);
   localparam int FIRST_RSVD = NUM_SRC - NUM_RSVD;

   for (genvar c = 0; c < 2; c++) begin : g_c
      AST_REQ_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n) req[c] |-> lvl[c] > $past(cur[c])); // R6
      AST_REQ_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) req[c] |-> lvl[c] != '0); // R3
      AST_NO_RSVD_VEC: assert property (@(posedge clk) disable iff (!rst_n) req[c] |-> int'(vec[c]) < FIRST_RSVD); // R4
      AST_ACK_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (ack[c] && req[c] && !full[c]) |=> (!req[c] && cur[c] == $past(lvl[c]))); // R9
   end

   AST_CRIT_DELAY: assert property (@(posedge clk) disable iff (!rst_n) $rose(crit_o) |-> $past(nmi_i)); // R11
   AST_CRIT_DROP: assert property (@(posedge clk) disable iff (!rst_n) $fell(crit_o) |-> !$past(nmi_i)); // R11

endmodule

bind prio_intc intc_chk #(
   .NUM_SRC(NUM_SRC), .NUM_RSVD(NUM_RSVD), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .nmi_i  (nmi_i),
   .crit_o (crit_o),
   .req    (req_w),
   .ack    (ack_w),
   .full   (full_w),
   .vec    (vec_w),
   .lvl    (lvl_w),
   .cur    (cur_w)
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
   localparam int NS    = 40;
   localparam int NR    = 4;
   localparam int NSW   = 8;
   localparam int DEPTH = 4;
   localparam int LIVE  = NS - NR;
   localparam int CFG   = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq = '0;
   logic          nmi = 1'b0;
   logic          wr_en = 1'b0;
   logic [6:0]    wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [6:0]    rd_addr = '0;
   logic [7:0]    rd_data;
   logic          ack_cpu = 1'b0, ack_iop = 1'b0;
   logic          req_cpu, req_iop, crit;
   logic [5:0]    vec_cpu, vec_iop;

   int checks = 0;
   int errors = 0;

   int       prio_m [NS];
   int       steer_m [NS];
   bit [7:0] sw_m;
   int       cur_m [2];
   int       stk_m [2][DEPTH];
   int       sp_m [2];

   always #2 clk = ~clk;

   prio_intc #(
      .NUM_SRC(NS), .NUM_RSVD(NR), .NUM_SW(NSW), .PRIO_W(4),
      .STACK_DEPTH(DEPTH), .DATA_W(8)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ack_cpu_i(ack_cpu), .ack_iop_i(ack_iop),
      .req_cpu_o(req_cpu), .vec_cpu_o(vec_cpu),
      .req_iop_o(req_iop), .vec_iop_o(vec_iop), .crit_o(crit)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Returns level*1024 + index of the winner for context c (level 0: none)
   function automatic int pick(input int c);
      int bl = 0, bi = 0;
      for (int i = 0; i < NS; i++) begin
         bit p;
         if (i < NSW)       p = sw_m[i];
         else if (i < LIVE) p = irq[i];
         else               p = 1'b0;
         if (p && steer_m[i] == c && prio_m[i] > bl) begin
            bl = prio_m[i];
            bi = i;
         end
      end
      return bl * 1024 + bi;
   endfunction

   task automatic check_out(input string tag);
      for (int c = 0; c < 2; c++) begin
         int p    = pick(c);
         int ereq = (p / 1024 > cur_m[c]) ? 1 : 0;
         int areq = (c == 0) ? int'(req_cpu) : int'(req_iop);
         int avec = (c == 0) ? int'(vec_cpu) : int'(vec_iop);
         chk({tag, " req"}, areq, ereq);
         if (ereq == 1) chk({tag, " vec"}, avec, p % 1024);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 7'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      rd_addr = 7'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic set_cfg(input int i, input int p, input int s);
      wr(CFG + i, (s << 4) | p);
      if (i < LIVE) begin
         prio_m[i] = p; steer_m[i] = s;
      end
   endtask

   task automatic set_cur(input int c, input int v);
      wr(c, v);
      cur_m[c] = v;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic do_ack(input int c, input string tag);
      int p = pick(c);
      @(negedge clk);
      if (c == 0) ack_cpu = 1'b1; else ack_iop = 1'b1;
      @(negedge clk);
      ack_cpu = 1'b0; ack_iop = 1'b0;
      if (sp_m[c] < DEPTH) begin
         stk_m[c][sp_m[c]] = cur_m[c];
         sp_m[c]++;
         cur_m[c] = p / 1024;
         chk({tag, " req low after ack"}, (c == 0) ? int'(req_cpu) : int'(req_iop), 0);
      end else begin
         chk({tag, " ack ignored, req stays"}, (c == 0) ? int'(req_cpu) : int'(req_iop), 1);
      end
   endtask

   task automatic do_eoi(input int c);
      wr(2 + c, 0);
      if (sp_m[c] > 0) begin
         sp_m[c]--;
         cur_m[c] = stk_m[c][sp_m[c]];
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int v;
      void'($urandom(32'd20240917));
      for (int i = 0; i < NS; i++) begin prio_m[i] = 0; steer_m[i] = 0; end
      sw_m = '0; cur_m[0] = 0; cur_m[1] = 0; sp_m[0] = 0; sp_m[1] = 0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      chk("R12 req_cpu", int'(req_cpu), 0);
      chk("R12 req_iop", int'(req_iop), 0);
      chk("R12 crit", int'(crit), 0);
      rd(0, v); chk("R12 cur main", v, 0);
      rd(CFG + 10, v); chk("R12 cfg", v, 0);
      rd(4, v); chk("R12 sw pending", v, 0);

      // R8: two-cycle latency from line to outputs
      set_cfg(10, 5, 0);
      settle();
      chk("R8 idle", int'(req_cpu), 0);
      @(negedge clk); irq[10] = 1'b1;
      @(negedge clk); chk("R8 after one edge", int'(req_cpu), 0);
      @(negedge clk); chk("R8 after two edges", int'(req_cpu), 1);
      chk("R8 vec", int'(vec_cpu), 10);

      // R2: tie goes to lower index
      set_cfg(12, 5, 0); irq[12] = 1'b1; settle();
      chk("R2 tie vec", int'(vec_cpu), 10);
      check_out("R2");

      // R1: higher level wins
      set_cfg(20, 9, 0); irq[20] = 1'b1; settle();
      chk("R1 higher vec", int'(vec_cpu), 20);

      // R3: priority 0 disables
      set_cfg(20, 0, 0); settle();
      chk("R3 disabled vec", int'(vec_cpu), 10);
      check_out("R3");

      // R7: steering
      set_cfg(12, 7, 1); settle();
      chk("R7 iop req", int'(req_iop), 1);
      chk("R7 iop vec", int'(vec_iop), 12);
      chk("R7 cpu vec", int'(vec_cpu), 10);

      // R6: strict masking by current priority
      set_cur(0, 5); settle();
      chk("R6 equal masked", int'(req_cpu), 0);
      set_cur(0, 4); settle();
      chk("R6 below passes", int'(req_cpu), 1);
      set_cur(0, 0); settle();

      // R4: reserved position
      set_cfg(37, 15, 0); irq[37] = 1'b1; settle();
      rd(CFG + 37, v); chk("R4 reserved cfg reads 0", v, 0);
      chk("R4 reserved no request", int'(vec_cpu), 10);

      // R5: software sources
      set_cfg(3, 14, 0); irq[3] = 1'b1; settle();
      chk("R5 hw line ignored", int'(vec_cpu), 10);
      wr(4, 8'h08); sw_m[3] = 1'b1; settle();
      chk("R5 set vec", int'(vec_cpu), 3);
      rd(4, v); chk("R5 pending read", v, 8'h08);
      wr(5, 8'h08); sw_m[3] = 1'b0; settle();
      chk("R5 clear vec", int'(vec_cpu), 10);
      irq[3] = 1'b0; irq[37] = 1'b0;

      // R9 and R10: nesting with the stack
      do_ack(0, "R9 first");
      rd(0, v); chk("R9 cur raised", v, 5);
      set_cfg(25, 11, 0); irq[25] = 1'b1; settle();
      chk("R9 nested req", int'(req_cpu), 1);
      chk("R9 nested vec", int'(vec_cpu), 25);
      do_ack(0, "R9 nested");
      rd(0, v); chk("R9 cur nested", v, 11);
      do_eoi(0); rd(0, v); chk("R10 pop to 5", v, 5);
      do_eoi(0); rd(0, v); chk("R10 pop to 0", v, 0);
      do_eoi(0); rd(0, v); chk("R10 empty pop", v, 0);
      settle(); check_out("R10 after unwind");

      // R10: full stack
      irq[10] = 1'b0; irq[12] = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         set_cur(0, k); settle();
         do_ack(0, "R10 fill");
         rd(0, v); chk("R10 fill cur", v, 11);
      end
      set_cur(0, 4); settle();
      chk("R10 req before full ack", int'(req_cpu), 1);
      do_ack(0, "R10 full");
      rd(0, v); chk("R10 full cur unchanged", v, 4);
      for (int k = DEPTH - 1; k >= 0; k--) begin
         do_eoi(0); rd(0, v); chk("R10 lifo", v, k);
      end
      do_eoi(0); rd(0, v); chk("R10 empty again", v, 0);

      // R11: urgent path ignores masking
      set_cur(0, 15);
      @(negedge clk); nmi = 1'b1;
      chk("R11 not yet", int'(crit), 0);
      @(negedge clk); chk("R11 asserted", int'(crit), 1);
      nmi = 1'b0;
      @(negedge clk); chk("R11 released", int'(crit), 0);
      set_cur(0, 0);

      // R1, R6, R7: random rounds
      for (int r = 0; r < 40; r++) begin
         for (int i = 0; i < NS; i++) set_cfg(i, int'($urandom_range(15)), int'($urandom_range(1)));
         irq = NS'({$urandom, $urandom});
         wr(5, 8'hFF); sw_m = '0;
         v = int'($urandom_range(255));
         wr(4, v); sw_m = 8'(v);
         set_cur(0, int'($urandom_range(15)));
         set_cur(1, int'($urandom_range(15)));
         settle();
         check_out("R1 R6 R7 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule